// File: doc/BRIEF.md
# Fully Associative Translation Cache with Global Entries

This block caches recent translations from virtual page numbers to physical frame numbers. Every stored tag is compared with the lookup page number in parallel. On a hit, the frame number and the cached protection bits (writable, user-accessible, dirty) come back combinationally in the same cycle. When a lookup misses, the miss output tells the requester to run a table walk. The walk result is later presented on the fill port, and the block stores it without any further handshake.

Two kinds of removal are supported. A single-page invalidate clears the entry for one virtual page, whether or not that entry is global. A context-switch flush clears every entry that was not loaded with the global flag, and leaves global entries in place. A fill first reuses an entry that already holds the same page. Failing that, it takes the lowest-numbered empty entry. When the cache is full, a round-robin pointer picks the entry to evict.

Top module: `tlb_fa`

## Requirements
- R1: After reset every entry is invalid, every lookup misses, and the round-robin pointer selects entry 0.
- R2: With `lk_valid_i` high, `lk_hit_o` rises in the same cycle when a valid entry's page number equals `lk_vpn_i`. On a hit the block drives that entry's frame, writable, user and dirty values. `lk_miss_o` equals `lk_valid_i` and not `lk_hit_o`. With `lk_valid_i` low, both outputs are low.
- R3: A fill presented in one cycle can be looked up from the next cycle onward.
- R4: A fill for a page number already held overwrites that entry. No two valid entries ever hold the same page number.
- R5: A fill for a page number not held goes to the lowest-indexed invalid entry when one exists.
- R6: When every entry is valid, a fill for an absent page replaces the entry at the round-robin pointer. The pointer then advances by one, wrapping from ENTRIES-1 to 0. Fills of any other kind leave the pointer unchanged.
- R7: A context flush invalidates every entry loaded with `fill_global_i` low and keeps every entry loaded with it high.
- R8: A page invalidate removes the entry matching `inv_vpn_i`, global or not.
- R9: An invalidate or flush in the same cycle as a lookup acts first. A page being invalidated misses, and during a flush only global entries can hit.
- R10: A fill in the same cycle as an invalidate or flush is applied after them, so the filled entry is valid afterwards. Entry selection for the fill uses the contents held before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lk_valid_i | input | 1 | Lookup request |
| lk_vpn_i | input | VPN_W | Lookup virtual page number |
| lk_hit_o | output | 1 | Lookup found a translation |
| lk_miss_o | output | 1 | Lookup needs a table walk |
| lk_pfn_o | output | PFN_W | Frame number on hit |
| lk_write_o | output | 1 | Page writable |
| lk_user_o | output | 1 | Page user-accessible |
| lk_dirty_o | output | 1 | Page dirty |
| fill_valid_i | input | 1 | Load a walk result |
| fill_vpn_i | input | VPN_W | Page number to load |
| fill_pfn_i | input | PFN_W | Frame number to load |
| fill_write_i | input | 1 | Writable flag to load |
| fill_user_i | input | 1 | User flag to load |
| fill_dirty_i | input | 1 | Dirty flag to load |
| fill_global_i | input | 1 | Entry survives context flush |
| inv_page_i | input | 1 | Invalidate one page |
| inv_vpn_i | input | VPN_W | Page to invalidate |
| flush_ctx_i | input | 1 | Context-switch flush of non-global entries |

## Verification
The bench builds the block with ENTRIES=4, VPN_W=8 and PFN_W=8. With only four entries, the cache fills after a handful of walks, and the round-robin pointer wraps many times within a few thousand cycles. With a narrow page number space, random lookups, invalidates and fills keep colliding on the same pages. Together these make replacement order, duplicate-fill overwrite, and same-cycle collisions of invalidate, flush, fill and lookup occur often instead of rarely.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef struct packed {
    logic dirty;
    logic user;
    logic write;
  } tlb_perm_t;
endpackage

// File: rtl/tlb_cam_cmp.sv
module tlb_cam_cmp #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned VPN_W   = 20
) (
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [VPN_W-1:0]   tag_i [ENTRIES],
  input  logic [VPN_W-1:0]   key_i,
  output logic [ENTRIES-1:0] match_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (tag_i[g] == key_i);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fill_i,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [ENTRIES-1:0] match_i,
  output logic [IDX_W-1:0]   way_o
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] match_idx, free_idx;
  logic             has_match, has_free;

  always_comb begin
    match_idx = '0;
    free_idx  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_i[i]) match_idx = IDX_W'(i);
    end
    // descending scan leaves the lowest free index
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) free_idx = IDX_W'(i);
    end
  end

  assign has_match = |match_i;
  assign has_free  = ~&valid_i;

  always_comb begin
    if (has_match)     way_o = match_idx;
    else if (has_free) way_o = free_idx;
    else               way_o = rr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q <= '0;
    end else if (fill_i && !has_match && !has_free) begin
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_store.sv
module tlb_store import tlb_pkg::*; #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned PFN_W   = 20,
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ENTRIES-1:0] clr_i,
  input  logic               wr_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [VPN_W-1:0]   wr_vpn_i,
  input  logic [PFN_W-1:0]   wr_pfn_i,
  input  tlb_perm_t          wr_perm_i,
  input  logic               wr_glob_i,
  output logic [ENTRIES-1:0] valid_o,
  output logic [ENTRIES-1:0] glob_o,
  output logic [VPN_W-1:0]   tag_o  [ENTRIES],
  output logic [PFN_W-1:0]   pfn_o  [ENTRIES],
  output tlb_perm_t          perm_o [ENTRIES]
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic sel;
    assign sel = wr_i && (wr_idx_i == IDX_W'(g));

    // write wins over clear: fill lands after invalidate/flush
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o[g] <= 1'b0;
        glob_o[g]  <= 1'b0;
      end else if (sel) begin
        valid_o[g] <= 1'b1;
        glob_o[g]  <= wr_glob_i;
      end else if (clr_i[g]) begin
        valid_o[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk_i) begin
      if (sel) begin
        tag_o[g]  <= wr_vpn_i;
        pfn_o[g]  <= wr_pfn_i;
        perm_o[g] <= wr_perm_i;
      end
    end
  end
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa import tlb_pkg::*; #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned PFN_W   = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lk_valid_i,
  input  logic [VPN_W-1:0] lk_vpn_i,
  output logic             lk_hit_o,
  output logic             lk_miss_o,
  output logic [PFN_W-1:0] lk_pfn_o,
  output logic             lk_write_o,
  output logic             lk_user_o,
  output logic             lk_dirty_o,
  input  logic             fill_valid_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PFN_W-1:0] fill_pfn_i,
  input  logic             fill_write_i,
  input  logic             fill_user_i,
  input  logic             fill_dirty_i,
  input  logic             fill_global_i,
  input  logic             inv_page_i,
  input  logic [VPN_W-1:0] inv_vpn_i,
  input  logic             flush_ctx_i
);
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] valid_q, glob_q;
  logic [VPN_W-1:0]   tag_q  [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  tlb_perm_t          perm_q [ENTRIES];

  logic [ENTRIES-1:0] lk_match, fill_match, inv_match, clr_vec, lk_sel;
  logic [IDX_W-1:0]   fill_way;
  tlb_perm_t          fill_perm, lk_perm;

  tlb_cam_cmp #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_cmp_lk (
    .valid_i(valid_q), .tag_i(tag_q), .key_i(lk_vpn_i), .match_o(lk_match)
  );
  tlb_cam_cmp #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_cmp_fill (
    .valid_i(valid_q), .tag_i(tag_q), .key_i(fill_vpn_i), .match_o(fill_match)
  );
  tlb_cam_cmp #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_cmp_inv (
    .valid_i(valid_q), .tag_i(tag_q), .key_i(inv_vpn_i), .match_o(inv_match)
  );

  assign clr_vec = (inv_page_i  ? inv_match          : '0)
                 | (flush_ctx_i ? (valid_q & ~glob_q) : '0);

  // removals of this cycle already hide the entry from the lookup
  assign lk_sel = lk_valid_i ? (lk_match & ~clr_vec) : '0;

  always_comb begin
    lk_pfn_o = '0;
    lk_perm  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_sel[i]) begin
        lk_pfn_o = lk_pfn_o | pfn_q[i];
        lk_perm  = lk_perm  | perm_q[i];
      end
    end
  end

  assign lk_hit_o   = |lk_sel;
  assign lk_miss_o  = lk_valid_i && !lk_hit_o;
  assign lk_write_o = lk_perm.write;
  assign lk_user_o  = lk_perm.user;
  assign lk_dirty_o = lk_perm.dirty;

  assign fill_perm = '{dirty: fill_dirty_i, user: fill_user_i, write: fill_write_i};

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fill_i  (fill_valid_i),
    .valid_i (valid_q),
    .match_i (fill_match),
    .way_o   (fill_way)
  );

  tlb_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_vec),
    .wr_i      (fill_valid_i),
    .wr_idx_i  (fill_way),
    .wr_vpn_i  (fill_vpn_i),
    .wr_pfn_i  (fill_pfn_i),
    .wr_perm_i (fill_perm),
    .wr_glob_i (fill_global_i),
    .valid_o   (valid_q),
    .glob_o    (glob_q),
    .tag_o     (tag_q),
    .pfn_o     (pfn_q),
    .perm_o    (perm_q)
  );
endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned PFN_W   = 20
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               lk_valid_i,
  input logic [VPN_W-1:0]   lk_vpn_i,
  input logic               lk_hit_o,
  input logic               lk_miss_o,
  input logic [PFN_W-1:0]   lk_pfn_o,
  input logic               fill_valid_i,
  input logic [VPN_W-1:0]   fill_vpn_i,
  input logic [PFN_W-1:0]   fill_pfn_i,
  input logic               fill_global_i,
  input logic               inv_page_i,
  input logic [VPN_W-1:0]   inv_vpn_i,
  input logic               flush_ctx_i,
  input logic [ENTRIES-1:0] valid_q_i,
  input logic [ENTRIES-1:0] glob_q_i,
  input logic [ENTRIES-1:0] lk_match_i
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  AST_HIT_MISS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |-> (lk_hit_o != lk_miss_o)); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |-> (!lk_hit_o && !lk_miss_o)); // R2

  AST_NO_DUP_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_match_i)); // R4

  AST_INV_BEATS_LOOKUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_page_i && lk_valid_i && inv_vpn_i == lk_vpn_i) |-> !lk_hit_o); // R9

  AST_FLUSH_KEEPS_GLOBAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(flush_ctx_i) && !$past(fill_valid_i))
      |-> ((valid_q_i & ~glob_q_i) == '0)); // R7

  AST_FILL_VISIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(fill_valid_i) && lk_valid_i && lk_vpn_i == $past(fill_vpn_i)
     && !(inv_page_i && inv_vpn_i == lk_vpn_i)
     && !(flush_ctx_i && !$past(fill_global_i)))
      |-> (lk_hit_o && lk_pfn_o == $past(fill_pfn_i))); // R3 R10

  AST_INV_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(inv_page_i)
     && !($past(fill_valid_i) && $past(fill_vpn_i) == $past(inv_vpn_i))
     && lk_valid_i && lk_vpn_i == $past(inv_vpn_i))
      |-> !lk_hit_o); // R8
endmodule

bind tlb_fa tlb_fa_chk #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .lk_valid_i    (lk_valid_i),
  .lk_vpn_i      (lk_vpn_i),
  .lk_hit_o      (lk_hit_o),
  .lk_miss_o     (lk_miss_o),
  .lk_pfn_o      (lk_pfn_o),
  .fill_valid_i  (fill_valid_i),
  .fill_vpn_i    (fill_vpn_i),
  .fill_pfn_i    (fill_pfn_i),
  .fill_global_i (fill_global_i),
  .inv_page_i    (inv_page_i),
  .inv_vpn_i     (inv_vpn_i),
  .flush_ctx_i   (flush_ctx_i),
  .valid_q_i     (valid_q),
  .glob_q_i      (glob_q),
  .lk_match_i    (lk_match)
);

// File: tb/tlb_fa_tb_top.sv
`timescale 1ns/1ps
module tlb_fa_tb_top;
  localparam int N  = 4;
  localparam int VW = 8;
  localparam int PW = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic          lk_valid = 0, fill_valid = 0, fill_w = 0, fill_u = 0, fill_d = 0;
  logic          fill_g = 0, inv_page = 0, flush = 0;
  logic [VW-1:0] lk_vpn = '0, fill_vpn = '0, inv_vpn = '0;
  logic [PW-1:0] fill_pfn = '0;
  logic          hit, miss, w_o, u_o, d_o;
  logic [PW-1:0] pfn_o;

  tlb_fa #(.ENTRIES(N), .VPN_W(VW), .PFN_W(PW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .lk_valid_i(lk_valid), .lk_vpn_i(lk_vpn),
    .lk_hit_o(hit), .lk_miss_o(miss), .lk_pfn_o(pfn_o),
    .lk_write_o(w_o), .lk_user_o(u_o), .lk_dirty_o(d_o),
    .fill_valid_i(fill_valid), .fill_vpn_i(fill_vpn), .fill_pfn_i(fill_pfn),
    .fill_write_i(fill_w), .fill_user_i(fill_u), .fill_dirty_i(fill_d),
    .fill_global_i(fill_g), .inv_page_i(inv_page), .inv_vpn_i(inv_vpn),
    .flush_ctx_i(flush)
  );

  int    n_chk = 0, n_bad = 0;
  bit    done = 0;
  string cur_req = "R1";

  // reference state
  bit m_v[N];
  bit m_g[N];
  int m_vpn[N];
  int m_pfn[N];
  int m_rr = 0;

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // perm bits are taken from pfn: write=bit0, user=bit1, dirty=bit2
  task automatic cyc(input bit lv, input int lvpn, input bit fv, input int fvpn,
                     input int fpfn, input bit fg, input bit iv, input int ivpn,
                     input bit fl);
    bit e_hit, e_miss, ok;
    int e_pfn, slot;
    @(negedge clk);
    lk_valid = lv; lk_vpn = VW'(lvpn);
    fill_valid = fv; fill_vpn = VW'(fvpn); fill_pfn = PW'(fpfn); fill_g = fg;
    fill_w = fpfn[0]; fill_u = fpfn[1]; fill_d = fpfn[2];
    inv_page = iv; inv_vpn = VW'(ivpn); flush = fl;
    #1;
    e_hit = 0; e_pfn = 0;
    for (int i = 0; i < N; i++) begin
      if (lv && m_v[i] && m_vpn[i] == lvpn && !(iv && ivpn == lvpn) && !(fl && !m_g[i])) begin
        e_hit = 1; e_pfn = m_pfn[i];
      end
    end
    e_miss = lv && !e_hit;
    ok = (hit == e_hit) && (miss == e_miss) &&
         (!e_hit || (int'(pfn_o) == e_pfn && w_o == e_pfn[0] && u_o == e_pfn[1] && d_o == e_pfn[2]));
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: vpn=%0d got hit=%0b miss=%0b pfn=%0h wud=%0b%0b%0b exp hit=%0b miss=%0b pfn=%0h wud=%0b%0b%0b",
               cur_req, lvpn, hit, miss, pfn_o, w_o, u_o, d_o,
               e_hit, e_miss, e_pfn, e_pfn[0], e_pfn[1], e_pfn[2]);
    end
    @(posedge clk);
    if (fv) begin
      slot = -1;
      for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == fvpn) slot = i;
      if (slot < 0) for (int i = N - 1; i >= 0; i--) if (!m_v[i]) slot = i;
      if (slot < 0) begin
        slot = m_rr;
        m_rr = (m_rr + 1) % N;
      end
    end else begin
      slot = -1;
    end
    for (int i = 0; i < N; i++) begin
      if (iv && m_v[i] && m_vpn[i] == ivpn) m_v[i] = 0;
      if (fl && !m_g[i]) m_v[i] = 0;
    end
    if (slot >= 0) begin
      m_v[slot] = 1; m_g[slot] = fg; m_vpn[slot] = fvpn; m_pfn[slot] = fpfn;
    end
  endtask

  task automatic look(input int vpn);
    cyc(1, vpn, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic fill(input int vpn, input int pfn, input bit g);
    cyc(0, 0, 1, vpn, pfn, g, 0, 0, 0);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_g[i] = 0; m_vpn[i] = 0; m_pfn[i] = 0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    cur_req = "R1";  // empty after reset
    for (int v = 0; v < 6; v++) look(v);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);

    cur_req = "R5";  // fills go to lowest free entries
    for (int v = 0; v < N; v++) fill(10 + v, 8'h40 + v * 3, 0);
    cur_req = "R2";
    for (int v = 0; v < N; v++) look(10 + v);
    look(99);

    cur_req = "R6";  // full: round-robin eviction
    fill(20, 8'h71, 0);
    look(10); look(20);
    fill(21, 8'h72, 0);
    look(11); look(21);

    cur_req = "R8";
    cyc(0, 0, 0, 0, 0, 0, 1, 13, 0);
    look(13);
    cur_req = "R5";  // freed slot used before pointer
    fill(22, 8'h73, 0);
    look(12); look(22);

    cur_req = "R4";  // duplicate fill overwrites
    fill(12, 8'h5e, 0);
    look(12);
    fill(23, 8'h66, 0);
    look(12); look(20); look(22); look(23);

    cur_req = "R7";  // context flush keeps global
    fill(21, 8'h37, 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1);
    look(20); look(21); look(22); look(23);

    cur_req = "R8";  // invalidate removes global
    cyc(0, 0, 0, 0, 0, 0, 1, 21, 0);
    look(21);

    cur_req = "R9";
    fill(30, 8'h15, 0); fill(31, 8'h16, 0); fill(32, 8'h17, 1);
    cyc(1, 30, 0, 0, 0, 0, 1, 30, 0);
    cyc(1, 31, 0, 0, 0, 0, 0, 0, 1);
    cyc(1, 32, 0, 0, 0, 0, 0, 0, 1);

    cur_req = "R10";
    cyc(0, 0, 1, 40, 8'h2c, 0, 1, 40, 0);
    look(40);
    cyc(0, 0, 1, 41, 8'h2d, 0, 0, 0, 1);
    look(41); look(40);

    cur_req = "R2";  // random mix
    for (int k = 0; k < 4000; k++) begin
      cyc($urandom_range(0, 3) != 0, $urandom_range(0, 11),
          $urandom_range(0, 2) == 0, $urandom_range(0, 11), $urandom_range(0, 255),
          $urandom_range(0, 1), $urandom_range(0, 7) == 0, $urandom_range(0, 11),
          $urandom_range(0, 19) == 0);
    end

    finish_run();
  end
endmodule